// File: doc/BRIEF.md
# Counter-Based LRU Replacement Unit

This block keeps the recency order of the ways in every set of a set-associative cache and names the way to evict when the cache controller asks for one. Each set stores a small age counter for each way. A counter at the largest value marks the most recently used way. A counter at zero marks the least recently used way, which is the victim.

On each access the counters of the addressed set are read, updated and written back in the same cycle. The accessed way's counter goes to the top value. Every other counter that was above the accessed way's old value moves down by one. A replacement request is answered one clock later with a registered victim way and a one-cycle valid flag. Access and replacement share one set index. When both arrive in the same cycle, the victim is chosen from the counters as they stood before that access.

The output side is a two-state machine. In `OUT_IDLE`, `victim_valid` is low. In `OUT_VALID`, `victim_valid` is high. On each clock edge the machine moves to `OUT_VALID` when `repl_req` is high and to `OUT_IDLE` when it is low. The machine therefore stays in `OUT_VALID` while requests keep arriving.

Top module: `lru_repl_unit`

## Requirements
- R1: After reset, the counters of every set hold way w = value w. The first victim of any set is way 0. Draining a set (request a victim, access it, repeat) then yields ways 0, 1, 2, 3 in that order.
- R2: An access with `acc_valid` high sets the accessed way's counter to WAYS-1, which makes that way the last one to be chosen as victim.
- R3: On an access, each other way of the set whose counter exceeds the accessed way's old value is decremented by one. All remaining counters keep their values.
- R4: `victim_way` is the way of the addressed set whose counter is zero. It is presented on the clock edge after `repl_req` is sampled high.
- R5: `victim_valid` is high exactly in the cycle after a cycle with `repl_req` high, and low otherwise.
- R6: When `acc_valid` and `repl_req` are both high in one cycle, the victim comes from the counter values before that access.
- R7: An access changes only the counters of the set named by `set_idx`.
- R8: While `acc_valid` is low, `acc_way` has no effect on any counter.
- R9: In every set, exactly one way has counter zero at all times, so the counters of a set always form a permutation of 0..WAYS-1.
- R10: Accessing the way whose counter is already WAYS-1 leaves the set's counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | $clog2(SETS) | Set addressed by access and replacement |
| acc_valid | input | 1 | An access to `acc_way` happens this cycle |
| acc_way | input | $clog2(WAYS) | Way that was accessed |
| repl_req | input | 1 | Request a victim for `set_idx` |
| victim_way | output | $clog2(WAYS) | Way to evict, registered |
| victim_valid | output | 1 | `victim_way` answers the previous cycle's request |

## Verification
A counter left at a wrong value cannot be seen at the ports until it reaches zero and is reported as a victim. That can take up to WAYS-1 further drain rounds on that set. For this reason the bench drains a set completely after each scenario, which exposes the whole recency order through the victim sequence. A lost or duplicated zero shows up as a repeated or missing way within one drain. A wrong update rule shows up as a victim order that differs from the bench's model. The internal assertions catch a broken permutation or a missed MRU write on the first clock edge where it occurs.

// File: rtl/lru_pkg.sv
package lru_pkg;
    typedef enum logic [0:0] {
        OUT_IDLE  = 1'b0,
        OUT_VALID = 1'b1
    } out_state_t;
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update #(
    parameter int WAYS = 4,
    localparam int CW = $clog2(WAYS)
) (
    input  logic [WAYS*CW-1:0] row_in,
    input  logic [CW-1:0]      hit_way,
    output logic [WAYS*CW-1:0] row_out
);
    localparam logic [CW-1:0] TOP = CW'(WAYS - 1);

    logic [CW-1:0] old_age;

    always_comb begin
        old_age = row_in[hit_way*CW +: CW];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [CW-1:0] cur;
        assign cur = row_in[w*CW +: CW];
        always_comb begin
            if (CW'(w) == hit_way) begin
                row_out[w*CW +: CW] = TOP;
            end else if (cur > old_age) begin
                row_out[w*CW +: CW] = cur - 1'b1;
            end else begin
                row_out[w*CW +: CW] = cur;
            end
        end
    end
endmodule

// File: rtl/lru_zero_find.sv
module lru_zero_find #(
    parameter int WAYS = 4,
    localparam int CW = $clog2(WAYS)
) (
    input  logic [WAYS*CW-1:0] row_in,
    output logic [CW-1:0]      zero_way,
    output logic [WAYS-1:0]    zero_mask
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign zero_mask[w] = (row_in[w*CW +: CW] == '0);
    end

    always_comb begin
        zero_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (zero_mask[w]) begin
                zero_way = CW'(w);
            end
        end
    end
endmodule

// File: rtl/lru_repl_unit.sv
module lru_repl_unit #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int CW = $clog2(WAYS),
    localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_idx,
    input  logic          acc_valid,
    input  logic [CW-1:0] acc_way,
    input  logic          repl_req,
    output logic [CW-1:0] victim_way,
    output logic          victim_valid
);
    import lru_pkg::*;

    localparam logic [CW-1:0] TOP = CW'(WAYS - 1);

    logic [WAYS*CW-1:0] age_q [SETS];
    logic [WAYS*CW-1:0] rd_row;
    logic [WAYS*CW-1:0] wr_row;
    logic [CW-1:0]      pick_way;
    logic [WAYS-1:0]    zero_mask;
    logic [CW-1:0]      victim_q;
    out_state_t         st_q;
    out_state_t         st_d;

    assign rd_row = age_q[set_idx];

    lru_age_update #(.WAYS(WAYS)) u_upd (
        .row_in  (rd_row),
        .hit_way (acc_way),
        .row_out (wr_row)
    );

    lru_zero_find #(.WAYS(WAYS)) u_zero (
        .row_in    (rd_row),
        .zero_way  (pick_way),
        .zero_mask (zero_mask)
    );

    // counter storage: reset to a permutation, written on access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w*CW +: CW] <= CW'(w);
                end
            end
        end else if (acc_valid) begin
            age_q[set_idx] <= wr_row;
        end
    end

    // output state machine
    always_comb begin
        st_d = repl_req ? OUT_VALID : OUT_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= OUT_IDLE;
            victim_q <= '0;
        end else begin
            st_q <= st_d;
            if (repl_req) begin
                victim_q <= pick_way;
            end
        end
    end

    always_comb begin
        victim_way = victim_q;
        unique case (st_q)
            OUT_IDLE:  victim_valid = 1'b0;
            OUT_VALID: victim_valid = 1'b1;
            default:   victim_valid = 1'b0;
        endcase
    end

    // checker state: remember last access to verify its MRU write
    logic          chk_acc;
    logic [SW-1:0] chk_set;
    logic [CW-1:0] chk_way;
    logic [CW-1:0] chk_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_acc <= 1'b0;
            chk_set <= '0;
            chk_way <= '0;
        end else begin
            chk_acc <= acc_valid;
            chk_set <= set_idx;
            chk_way <= acc_way;
        end
    end

    always_comb begin
        chk_age = age_q[chk_set][chk_way*CW +: CW];
    end

    // R9
    one_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_mask) == 1);

    // R2
    mru_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_acc |-> chk_age == TOP);

    // R5
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        repl_req |=> victim_valid);

    // R5
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !repl_req |=> !victim_valid);

    // R4
    victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !repl_req |=> $stable(victim_way));
endmodule

// File: tb/sim_lru_repl_unit.sv
module sim_lru_repl_unit;
    localparam int WAYS = 4;
    localparam int SETS = 16;
    localparam int CW = $clog2(WAYS);
    localparam int SW = $clog2(SETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] set_idx = '0;
    logic          acc_valid = 1'b0;
    logic [CW-1:0] acc_way = '0;
    logic          repl_req = 1'b0;
    logic [CW-1:0] victim_way;
    logic          victim_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int model [SETS][WAYS];

    always #10 clk = ~clk;

    lru_repl_unit #(.WAYS(WAYS), .SETS(SETS)) u0 (
        .clk, .rst_n, .set_idx, .acc_valid, .acc_way, .repl_req,
        .victim_way, .victim_valid
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_zero(input int s);
        for (int w = 0; w < WAYS; w++) if (model[s][w] == 0) return w;
        return -1;
    endfunction

    // apply the update rule of R2 and R3
    function automatic void model_access(input int s, input int w);
        int x = model[s][w];
        for (int v = 0; v < WAYS; v++) begin
            if (v == w) model[s][v] = WAYS - 1;
            else if (model[s][v] > x) model[s][v] = model[s][v] - 1;
        end
    endfunction

    // one cycle, starting and ending at a falling edge
    task automatic step(input int s, input bit acc, input int w, input bit repl,
                        input string tag, output int vic);
        int exp_v = model_zero(s);
        set_idx = SW'(s); acc_valid = acc; acc_way = CW'(w); repl_req = repl;
        if (acc) model_access(s, w);
        @(negedge clk);
        chk(victim_valid == repl, "R5 valid flag", int'(victim_valid), int'(repl));
        vic = int'(victim_way);
        if (repl) chk(victim_way == CW'(exp_v), tag, int'(victim_way), exp_v);
        acc_valid = 1'b0; repl_req = 1'b0;
    endtask

    // R4/R9: expose whole order of a set through successive victims
    task automatic drain(input int s, input string tag);
        int v;
        logic [WAYS-1:0] seen = '0;
        for (int i = 0; i < WAYS; i++) begin
            step(s, 1'b0, 0, 1'b1, tag, v);
            seen[v] = 1'b1;
            step(s, 1'b1, v, 1'b0, tag, v);
        end
        chk(&seen, "R9 distinct victims in drain", int'(seen), (1 << WAYS) - 1);
    endtask

    task automatic t_reset;
        int v;
        chk(victim_valid == 1'b0, "R1 reset valid", int'(victim_valid), 0);
        for (int s = 0; s < SETS; s++) step(s, 1'b0, 0, 1'b1, "R1 first victim", v);
        drain(4, "R1 reset order");
    endtask

    task automatic t_basic;
        int v;
        step(3, 1'b1, 2, 1'b0, "R2", v);
        step(3, 1'b1, 0, 1'b0, "R3", v);
        step(3, 1'b1, 3, 1'b0, "R3", v);
        drain(3, "R3 order after accesses");
        step(11, 1'b1, 1, 1'b0, "R2", v);
        step(11, 1'b0, 0, 1'b1, "R4 victim", v);
        drain(11, "R2 accessed way last");
    endtask

    task automatic t_same_cycle;
        int v;
        step(5, 1'b1, 0, 1'b1, "R6 pre-update victim", v);
        step(5, 1'b0, 0, 1'b1, "R6 following victim", v);
        drain(5, "R6 order");
    endtask

    task automatic t_isolation;
        int v;
        step(7, 1'b1, 0, 1'b0, "R7", v);
        step(7, 1'b1, 1, 1'b0, "R7", v);
        step(7, 1'b1, 2, 1'b0, "R7", v);
        drain(8, "R7 neighbour set untouched");
        drain(7, "R7 accessed set");
    endtask

    task automatic t_ignore;
        int v;
        step(9, 1'b0, 0, 1'b0, "R8", v);
        step(9, 1'b0, 3, 1'b0, "R8", v);
        drain(9, "R8 way ignored without valid");
    endtask

    task automatic t_mru_repeat;
        int v;
        step(10, 1'b1, 1, 1'b0, "R10", v);
        step(10, 1'b1, 1, 1'b0, "R10", v);
        step(10, 1'b1, 1, 1'b0, "R10", v);
        drain(10, "R10 repeated MRU access");
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) model[s][w] = w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_same_cycle();
        t_isolation();
        t_ignore();
        t_mru_repeat();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule